// File: doc/BRIEF.md
# Video Capture Field Sequencer

This block decides when incoming video is written to capture memory. It takes the video horizontal and vertical sync pulses, each with a programmable active level, and works out a field flag. The flag comes either from an external field input or from the phase of hsync at the vsync leading edge, and its polarity can be inverted. Software arms a capture by setting a start bit. The block then waits for a vsync leading edge, so that capture always begins on a field boundary. It raises a per-scanline capture qualifier for each field it captures. In single mode it clears the start bit by itself once the requested picture is complete.

While the start bit reads back as one, host access to capture memory is blocked. Software polls the bit to learn when memory is free again. Capture runs without end in continuous mode. In single mode it covers either one whole frame (both fields) or only the even or only the odd field. Progressive input has one field per frame. Vsync leading edges also raise even-field and odd-field interrupt pulses, each gated by its own enable. Cropping, scaling and address generation belong to a block further down the path.

Top module: `vcap_field_seq`

## Requirements
- R1: After reset, `busy`, `line_active`, `field_odd`, `irq_even` and `irq_odd` are all 0.
- R2: A write of 1 to the start bit (`start_wr` high with `start_val` = 1) while idle makes `busy` 1 in the next cycle. Capture does not begin until the next vsync leading edge.
- R3: With `cfg_single` = 0, capture runs on every field until a start write with `start_val` = 0. That write makes `busy` 0 in the next cycle, and capture stops.
- R4: With `cfg_single` = 1, `cfg_field_only` = 0 and interlaced input, capture begins at the first even-field vsync. It spans that field and the following odd field, and `busy` clears at the vsync leading edge that ends the odd field.
- R5: With `cfg_single` = 1, `cfg_field_only` = 1 and interlaced input, capture waits for the field selected by `cfg_odd_field` (0 = even, 1 = odd). It captures that one field, and `busy` clears at the next vsync leading edge.
- R6: With `cfg_progressive` = 1, a single capture begins at the next vsync leading edge of either field and covers exactly one field, whatever `cfg_field_only` says.
- R7: `cfg_hs_act_high` = 1 makes hsync active when the input is high, and 0 makes it active when the input is low. `cfg_vs_act_high` does the same for vsync.
- R8: With the internal field source, hsync active at the vsync leading edge marks the even field (`field_odd` = 0). Hsync inactive at that edge marks the odd field (`field_odd` = 1).
- R9: `cfg_ext_field` = 1 takes the field from `vid_fld_in` (1 = odd), sampled at the vsync leading edge. `cfg_field_inv` = 1 inverts whichever field source is selected.
- R10: `line_active` is 1 only while a field is being captured and neither hsync nor vsync is active.
- R11: Each vsync leading edge produces a one-cycle pulse on `irq_even` (new field even, `irq_en_even` = 1) or on `irq_odd` (new field odd, `irq_en_odd` = 1), and never on both at once.
- R12: `vsync_active` shows the synchronised active level of vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_hs_in | input | 1 | Raw video hsync |
| vid_vs_in | input | 1 | Raw video vsync |
| vid_fld_in | input | 1 | External field input, 1 = odd |
| start_wr | input | 1 | Write strobe for the start bit |
| start_val | input | 1 | Value written to the start bit |
| cfg_single | input | 1 | 1 = single capture, 0 = continuous |
| cfg_field_only | input | 1 | Single mode: 1 = one field, 0 = full frame |
| cfg_odd_field | input | 1 | Field-only capture: 1 = odd, 0 = even |
| cfg_hs_act_high | input | 1 | Hsync active level |
| cfg_vs_act_high | input | 1 | Vsync active level |
| cfg_ext_field | input | 1 | 1 = external field source |
| cfg_field_inv | input | 1 | Invert the selected field |
| cfg_progressive | input | 1 | 1 = progressive, 0 = interlaced |
| irq_en_even | input | 1 | Enable for the even-field interrupt |
| irq_en_odd | input | 1 | Enable for the odd-field interrupt |
| busy | output | 1 | Start bit readback; memory blocked while 1 |
| line_active | output | 1 | Capture qualifier for active scanline time |
| field_odd | output | 1 | Current field, 1 = odd |
| vsync_active | output | 1 | Synchronised vsync level |
| irq_even | output | 1 | Even-field vsync interrupt pulse |
| irq_odd | output | 1 | Odd-field vsync interrupt pulse |

## Verification
The bench sweeps every combination of single/continuous mode, frame/field choice, field selection, progressive input and both sync polarities. In each run it arms capture partway through a field of the wrong parity and then plays several alternating fields. This exposes a design that starts capture mid-field or on the wrong parity, because it would raise `line_active` in a field the model marks idle. It also exposes a design that clears the start bit one field early or late, because `busy` would disagree at a vsync boundary. A polarity or field-source inversion error flips `field_odd` and routes the interrupt to the wrong line. A qualifier that ignores vsync shows up as `line_active` high during the vertical interval.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_CAPT = 2'd2
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    second;   // one more field to capture after this one
        logic    irq_e;
        logic    irq_o;
    } seq_regs_t;

endpackage

// File: rtl/vcap_sync_cond.sv
module vcap_sync_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic act_high,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              lvl_d, lvl_q;

    always_comb begin
        chain_d = (chain_q << 1) | STAGES'(raw_in);
        lvl_d   = act_high ? chain_q[STAGES-1] : ~chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{~act_high}};
            lvl_q   <= 1'b0;
        end else begin
            chain_q <= chain_d;
            lvl_q   <= lvl_d;
        end
    end

    assign lvl  = lvl_q;
    assign rise = lvl_d & ~lvl_q;

    // R7: a leading edge lasts exactly one cycle
    p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/vcap_field_det.sv
module vcap_field_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_rise,
    input  logic hs_lvl,
    input  logic ext_raw,
    input  logic use_ext,
    input  logic invert,
    output logic fld_new,
    output logic fld_q
);
    logic [STAGES-1:0] ext_d, ext_q;
    logic              fld_d, fld_r;
    logic              src;

    always_comb begin
        ext_d   = (ext_q << 1) | STAGES'(ext_raw);
        src     = use_ext ? ext_q[STAGES-1] : ~hs_lvl;
        fld_new = src ^ invert;
        fld_d   = vs_rise ? fld_new : fld_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
            fld_r <= 1'b0;
        end else begin
            ext_q <= ext_d;
            fld_r <= fld_d;
        end
    end

    assign fld_q = fld_r;

    // R8: the field flag only moves at a vsync leading edge
    p_field_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> $stable(fld_q));

endmodule

// File: rtl/vcap_seq.sv
module vcap_seq
    import vcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_val,
    input  logic cfg_single,
    input  logic cfg_field_only,
    input  logic cfg_odd_field,
    input  logic cfg_progressive,
    input  logic vs_rise,
    input  logic fld_new,
    input  logic hs_lvl,
    input  logic vs_lvl,
    input  logic mask_even,
    input  logic mask_odd,
    output logic busy,
    output logic line_active,
    output logic irq_even,
    output logic irq_odd
);
    seq_regs_t r_d, r_q;
    logic      capt;

    always_comb begin
        r_d       = r_q;
        r_d.irq_e = vs_rise & ~fld_new & mask_even;
        r_d.irq_o = vs_rise &  fld_new & mask_odd;
        if (start_wr) begin
            if (!start_val)
                r_d.st = ST_IDLE;
            else if (r_q.st == ST_IDLE)
                r_d.st = ST_ARM;
        end else if (vs_rise) begin
            unique case (r_q.st)
                ST_ARM: begin
                    if (!cfg_single || cfg_progressive) begin
                        r_d.st     = ST_CAPT;
                        r_d.second = 1'b0;
                    end else if (cfg_field_only) begin
                        if (fld_new == cfg_odd_field) begin
                            r_d.st     = ST_CAPT;
                            r_d.second = 1'b0;
                        end
                    end else if (!fld_new) begin
                        r_d.st     = ST_CAPT;
                        r_d.second = 1'b1;
                    end
                end
                ST_CAPT: begin
                    if (cfg_single) begin
                        if (r_q.second)
                            r_d.second = 1'b0;
                        else
                            r_d.st = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, second: 1'b0, irq_e: 1'b0, irq_o: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign capt        = (r_q.st == ST_CAPT);
    assign busy        = (r_q.st != ST_IDLE);
    assign line_active = capt & ~hs_lvl & ~vs_lvl;
    assign irq_even    = r_q.irq_e;
    assign irq_odd     = r_q.irq_o;

    // R2: capture only ever begins right after a vsync leading edge
    p_capt_on_vsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capt) |-> $past(vs_rise));

    // R3: continuous capture persists until a stop write
    p_cont_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (capt && !cfg_single && !(start_wr && !start_val)) |=> capt);

    // R4: capture never ends between vsync edges without a write
    p_end_on_vsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (capt && !vs_rise && !start_wr) |=> capt);

    // R11: enabled even edge yields an even pulse
    p_irq_even_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise && !fld_new && mask_even) |=> irq_even);

    // R11: the two interrupt pulses are exclusive
    p_irq_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_even, irq_odd}));

endmodule

// File: rtl/vcap_field_seq.sv
module vcap_field_seq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vid_hs_in,
    input  logic vid_vs_in,
    input  logic vid_fld_in,
    input  logic start_wr,
    input  logic start_val,
    input  logic cfg_single,
    input  logic cfg_field_only,
    input  logic cfg_odd_field,
    input  logic cfg_hs_act_high,
    input  logic cfg_vs_act_high,
    input  logic cfg_ext_field,
    input  logic cfg_field_inv,
    input  logic cfg_progressive,
    input  logic irq_en_even,
    input  logic irq_en_odd,
    output logic busy,
    output logic line_active,
    output logic field_odd,
    output logic vsync_active,
    output logic irq_even,
    output logic irq_odd
);
    logic hs_lvl, hs_rise, vs_lvl, vs_rise, fld_new;

    vcap_sync_cond #(.STAGES(SYNC_STAGES)) u_hs (
        .clk(clk), .rst_n(rst_n), .raw_in(vid_hs_in), .act_high(cfg_hs_act_high),
        .lvl(hs_lvl), .rise(hs_rise)
    );

    vcap_sync_cond #(.STAGES(SYNC_STAGES)) u_vs (
        .clk(clk), .rst_n(rst_n), .raw_in(vid_vs_in), .act_high(cfg_vs_act_high),
        .lvl(vs_lvl), .rise(vs_rise)
    );

    vcap_field_det #(.STAGES(SYNC_STAGES)) u_fld (
        .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .hs_lvl(hs_lvl),
        .ext_raw(vid_fld_in), .use_ext(cfg_ext_field), .invert(cfg_field_inv),
        .fld_new(fld_new), .fld_q(field_odd)
    );

    vcap_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_val(start_val),
        .cfg_single(cfg_single), .cfg_field_only(cfg_field_only),
        .cfg_odd_field(cfg_odd_field), .cfg_progressive(cfg_progressive),
        .vs_rise(vs_rise), .fld_new(fld_new), .hs_lvl(hs_lvl), .vs_lvl(vs_lvl),
        .mask_even(irq_en_even), .mask_odd(irq_en_odd),
        .busy(busy), .line_active(line_active),
        .irq_even(irq_even), .irq_odd(irq_odd)
    );

    assign vsync_active = vs_lvl;

    // R7: an hsync leading edge means hsync is active in the next cycle
    p_hs_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> hs_lvl);

endmodule

// File: tb/vcap_field_seq_bench.sv
module vcap_field_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_a = 1'b0, vs_a = 1'b0, fld_in = 1'b0;
    logic start_wr = 1'b0, start_val = 1'b0;
    logic c_single = 0, c_fo = 0, c_osel = 0, c_hsp = 0, c_vsp = 0;
    logic c_ext = 0, c_inv = 0, c_prog = 0, m_e = 0, m_o = 0;
    logic busy, line_active, field_odd, vsync_active, irq_even, irq_odd;
    int n_chk = 0, n_fail = 0, n_ie = 0, n_io = 0;
    int mdl_st = 0, mdl_second = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vcap_field_seq u_vcap_field_seq (
        .clk(clk), .rst_n(rst_n),
        .vid_hs_in(hs_a ~^ c_hsp), .vid_vs_in(vs_a ~^ c_vsp), .vid_fld_in(fld_in),
        .start_wr(start_wr), .start_val(start_val),
        .cfg_single(c_single), .cfg_field_only(c_fo), .cfg_odd_field(c_osel),
        .cfg_hs_act_high(c_hsp), .cfg_vs_act_high(c_vsp),
        .cfg_ext_field(c_ext), .cfg_field_inv(c_inv), .cfg_progressive(c_prog),
        .irq_en_even(m_e), .irq_en_odd(m_o),
        .busy(busy), .line_active(line_active), .field_odd(field_odd),
        .vsync_active(vsync_active), .irq_even(irq_even), .irq_odd(irq_odd)
    );

    always @(negedge clk) begin
        if (irq_even) n_ie++;
        if (irq_odd)  n_io++;
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_start(input logic v);
        start_wr = 1'b1; start_val = v;
        @(negedge clk);
        start_wr = 1'b0;
        if (v && mdl_st == 0) mdl_st = 1;
        if (!v) mdl_st = 0;
    endtask

    // hs_f: parity the hsync phase implies; fexp: field value expected
    task automatic gen_field(input int hs_f, input int fexp, input string tag);
        n_ie = 0; n_io = 0;
        hs_a = (hs_f == 0);
        wait_n(3);
        vs_a = 1'b1;
        if (mdl_st == 1) begin
            if (!c_single || c_prog) begin mdl_st = 2; mdl_second = 0; end
            else if (c_fo) begin
                if (fexp == int'(c_osel)) begin mdl_st = 2; mdl_second = 0; end
            end else if (fexp == 0) begin mdl_st = 2; mdl_second = 1; end
        end else if (mdl_st == 2 && c_single) begin
            if (mdl_second != 0) mdl_second = 0; else mdl_st = 0;
        end
        wait_n(6);
        chk(field_odd, fexp, {tag, " R8/R9 field"});
        chk(busy, mdl_st != 0, {tag, " busy"});
        chk(vsync_active, 1, "R12 vsync level active");
        hs_a = 1'b0;
        wait_n(4);
        chk(line_active, 0, "R10 no qualifier in vsync");
        vs_a = 1'b0;
        for (int l = 0; l < 3; l++) begin
            hs_a = 1'b1;
            wait_n(5);
            if (l == 0) chk(line_active, 0, "R10 no qualifier in hsync");
            wait_n(1);
            hs_a = 1'b0;
            wait_n(6);
            chk(line_active, mdl_st == 2, {tag, " R10 line qualifier"});
            if (l == 0) chk(vsync_active, 0, "R12 vsync level idle");
            wait_n(3);
        end
        chk(n_ie, (fexp == 0 && m_e) ? 1 : 0, "R11 even irq count");
        chk(n_io, (fexp == 1 && m_o) ? 1 : 0, "R11 odd irq count");
    endtask

    initial begin
        wait_n(3);
        chk(busy, 0, "R1 busy reset");
        chk(line_active, 0, "R1 line reset");
        chk(field_odd, 0, "R1 field reset");
        chk(irq_even | irq_odd, 0, "R1 irq reset");
        rst_n = 1'b1;
        wait_n(4);

        for (int cfg = 0; cfg < 64; cfg++) begin
            string tag;
            int tgt, first;
            c_single = cfg[0]; c_fo = cfg[1]; c_osel = cfg[2]; c_prog = cfg[3];
            c_hsp = cfg[4]; c_vsp = cfg[5];
            m_e = cfg[4]; m_o = ~cfg[5];
            hs_a = 0; vs_a = 0;
            wait_n(10);
            tag = !c_single ? "R3" : c_prog ? "R6 R7" : c_fo ? "R5 R7" : "R4 R7";
            wr_start(1'b1);
            chk(busy, 1, "R2 busy after start");
            tgt = (c_single && c_fo) ? int'(c_osel) : 0;
            first = 1 - tgt;
            for (int k = 0; k < 5; k++) begin
                if (c_prog) gen_field(1, 1, tag);
                else gen_field((first + k) % 2, (first + k) % 2, tag);
            end
            if (!c_single) begin
                chk(busy, 1, "R3 still running");
                wr_start(1'b0);
                chk(busy, 0, "R3 stop write clears busy");
                gen_field(0, 0, "R3 after stop");
            end else begin
                chk(busy, 0, {tag, " start bit self-cleared"});
            end
        end

        // field source and inversion
        c_single = 1; c_fo = 0; c_prog = 0; c_hsp = 1; c_vsp = 1;
        m_e = 1; m_o = 1;
        wr_start(1'b0);
        wait_n(10);
        for (int x = 0; x < 8; x++) begin
            c_ext = x[0]; c_inv = x[1]; fld_in = x[2];
            wait_n(6);
            if (c_ext) gen_field(1 - x[2], x[2] ^ x[1], "R9 external");
            else gen_field(x[2], x[2] ^ x[1], "R9 internal invert");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule